// File: doc/BRIEF.md
# Dual Alarm Compare Unit

This block holds two independent alarm settings and compares them against the running time of day. The weekly alarm fires on a chosen set of weekdays at a given hour and minute. The daily alarm fires every day at a given hour and minute. Each alarm has an enable bit, a sticky match flag, and an active-low interrupt output of its own. The outputs model open-drain pins: high means released and low means pulled down.

A timekeeping counter outside this block supplies the current BCD minute, the BCD hour and the weekday number. It also supplies a one-cycle strobe in the cycle where those inputs first show a new minute. Comparison happens only on that strobe, so an alarm fires at most once per matching minute. The host sets the alarm fields and the control byte through a simple write port. After power-on, both alarms are disabled and both outputs are released.

Top module: `alarm_pair_top`

## Requirements
- R1: After reset, both interrupt outputs are high (released) and both alarms are disabled.
- R2: Register map (write port): 0 = weekly minute, 1 = weekly hour, 2 = weekday mask, 3 = daily minute, 4 = daily hour, 5 = control. In the control byte, bit 0 enables the weekly alarm, bit 1 enables the daily alarm, bit 4 is the weekly flag and bit 5 is the daily flag. When `min_tick` is high, the weekly alarm is enabled, minute bits 6:0 equal `cur_min[6:0]`, hour bits 5:0 equal `cur_hour[5:0]`, and mask bit d is set for `cur_wday` = d, then `irq_wk_n` is low from the next cycle.
- R3: The daily alarm matches on minute and hour alone, with the weekday ignored, and then drives `irq_dy_n` low from the next cycle.
- R4: No flag is set in a cycle without `min_tick`, or while the alarm is disabled. A control write that enables an alarm in the same cycle as a matching tick does not set its flag.
- R5: A set flag holds its output low until a control write puts 0 in that flag bit. A control write with 1 in the flag bit leaves the flag as it is.
- R6: A control write that clears an alarm's enable bit releases that alarm's output after the same edge. This holds even when a matching tick falls in the same cycle.
- R7: A write to an alarm's minute or hour field in the same cycle as a tick does not affect that tick's comparison; the tick compares against the value stored before the write.
- R8: A matching tick in the same cycle as a control write of 0 to that flag (enable kept at 1) leaves the flag set.
- R9: Hour bit 5, the PM bit in 12-hour format, takes part in the comparison, so 08 and PM-08 (0x28) are different hours.
- R10: A `cur_wday` value of 7 never matches the weekly alarm, whatever the mask.
- R11: The two alarms are independent: a match of one never changes the other's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cur_min | input | 8 | Current minute, BCD |
| cur_hour | input | 8 | Current hour, BCD, 12/24-hour format as in the counter |
| cur_wday | input | 3 | Current weekday number 0..6 |
| min_tick | input | 1 | One-cycle strobe: the time inputs show a new minute |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 3 | Host register address |
| wr_data | input | 8 | Host register write data |
| irq_wk_n | output | 1 | Weekly alarm interrupt, active low |
| irq_dy_n | output | 1 | Daily alarm interrupt, active low |

## Verification
The key collisions are a minute tick and a host write landing in the same cycle. Three kinds of write are checked this way: an alarm-field write, a control write that clears a flag, and a control write that changes an enable. The bench drives the tick and the write on the same clock edge. In each case it reads the interrupt pin after that edge and compares it with the rule for that case: the old field value decides the match, a match beats a flag clear, and a disable beats a match.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int DAYS   = 7;
  localparam int MIN_W  = 7;
  localparam int HOUR_W = 6;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;
  localparam int N_ALM  = 2;

  localparam logic [ADDR_W-1:0] A_WK_MIN  = 3'd0;
  localparam logic [ADDR_W-1:0] A_WK_HOUR = 3'd1;
  localparam logic [ADDR_W-1:0] A_WK_MASK = 3'd2;
  localparam logic [ADDR_W-1:0] A_DY_MIN  = 3'd3;
  localparam logic [ADDR_W-1:0] A_DY_HOUR = 3'd4;
  localparam logic [ADDR_W-1:0] A_CTRL    = 3'd5;

  localparam int CTRL_EN_LSB   = 0;
  localparam int CTRL_FLAG_LSB = 4;

  typedef struct packed {
    logic [MIN_W-1:0]  min;
    logic [HOUR_W-1:0] hour;
    logic [DAYS-1:0]   mask;
  } alarm_cfg_t;

  function automatic logic time_eq(input alarm_cfg_t cfg,
                                   input logic [DATA_W-1:0] cmin,
                                   input logic [DATA_W-1:0] chour);
    return (cfg.min == cmin[MIN_W-1:0]) && (cfg.hour == chour[HOUR_W-1:0]);
  endfunction

  function automatic logic day_hit(input logic [DAYS-1:0] mask,
                                   input logic [2:0] wday);
    logic r;
    r = 1'b0;
    for (int d = 0; d < DAYS; d++)
      if (wday == 3'(d)) r = mask[d];
    return r;
  endfunction
endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
  import alarm_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  output alarm_cfg_t [N_ALM-1:0] cfg,
  output logic [N_ALM-1:0]       en_q,
  output logic [N_ALM-1:0]       en_nxt,
  output logic                   ctrl_wr,
  output logic [N_ALM-1:0]       flag_keep
);
  alarm_cfg_t wk_q, dy_q;

  assign ctrl_wr   = wr_en && (wr_addr == A_CTRL);
  assign en_nxt    = ctrl_wr ? wr_data[CTRL_EN_LSB +: N_ALM] : en_q;
  assign flag_keep = wr_data[CTRL_FLAG_LSB +: N_ALM];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wk_q <= '0;
      dy_q <= '0;
      en_q <= '0;
    end else begin
      en_q <= en_nxt;
      if (wr_en) begin
        case (wr_addr)
          A_WK_MIN:  wk_q.min  <= wr_data[MIN_W-1:0];
          A_WK_HOUR: wk_q.hour <= wr_data[HOUR_W-1:0];
          A_WK_MASK: wk_q.mask <= wr_data[DAYS-1:0];
          A_DY_MIN:  dy_q.min  <= wr_data[MIN_W-1:0];
          A_DY_HOUR: dy_q.hour <= wr_data[HOUR_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    cfg[0] = wk_q;
    cfg[1] = dy_q;
    cfg[1].mask = '1;
  end
endmodule

// File: rtl/alarm_match.sv
module alarm_match
  import alarm_pkg::*;
#(
  parameter bit USE_WDAY = 1'b1
) (
  input  alarm_cfg_t        cfg,
  input  logic [DATA_W-1:0] cur_min,
  input  logic [DATA_W-1:0] cur_hour,
  input  logic [2:0]        cur_wday,
  input  logic              min_tick,
  output logic              hit
);
  logic day_ok;

  generate
    if (USE_WDAY) begin : g_wday
      assign day_ok = day_hit(cfg.mask, cur_wday);
    end else begin : g_any
      assign day_ok = 1'b1;
    end
  endgenerate

  assign hit = min_tick && day_ok && time_eq(cfg, cur_min, cur_hour);
endmodule

// File: rtl/alarm_flag.sv
module alarm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic en_now,
  input  logic en_next,
  input  logic clr_req,
  output logic flag_q
);
  logic flag_d;

  always_comb begin
    if (!en_next)              flag_d = 1'b0;
    else if (hit && en_now)    flag_d = 1'b1;
    else if (clr_req)          flag_d = 1'b0;
    else                       flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end
endmodule

// File: rtl/alarm_pair_top.sv
module alarm_pair_top
  import alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] cur_min,
  input  logic [DATA_W-1:0] cur_hour,
  input  logic [2:0]        cur_wday,
  input  logic              min_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              irq_wk_n,
  output logic              irq_dy_n
);
  alarm_cfg_t [N_ALM-1:0] cfg;
  logic [N_ALM-1:0] en_q, en_nxt, flag_keep, hit, flag_q;
  logic ctrl_wr;

  alarm_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cfg(cfg), .en_q(en_q), .en_nxt(en_nxt),
    .ctrl_wr(ctrl_wr), .flag_keep(flag_keep)
  );

  generate
    for (genvar i = 0; i < N_ALM; i++) begin : g_alm
      alarm_match #(.USE_WDAY(i == 0)) u_match (
        .cfg(cfg[i]), .cur_min(cur_min), .cur_hour(cur_hour),
        .cur_wday(cur_wday), .min_tick(min_tick), .hit(hit[i])
      );
      alarm_flag u_flag (
        .clk(clk), .rst_n(rst_n), .hit(hit[i]), .en_now(en_q[i]),
        .en_next(en_nxt[i]), .clr_req(ctrl_wr && !flag_keep[i]),
        .flag_q(flag_q[i])
      );
    end
  endgenerate

  assign irq_wk_n = !flag_q[0];
  assign irq_dy_n = !flag_q[1];
endmodule

// File: rtl/alarm_pair_chk.sv
module alarm_pair_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       min_tick,
  input logic       ctrl_wr,
  input logic [1:0] en_q,
  input logic [1:0] hit,
  input logic       irq_wk_n,
  input logic       irq_dy_n
);
  // R4
  wk_fall_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_wk_n) |-> $past(min_tick));
  // R4
  dy_fall_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_dy_n) |-> $past(min_tick));
  // R6
  wk_off_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[0] |-> irq_wk_n);
  // R6
  dy_off_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[1] |-> irq_dy_n);
  // R2
  wk_hit_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit[0] && en_q[0] |=> (!irq_wk_n || !en_q[0]));
  // R3
  dy_hit_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit[1] && en_q[1] |=> (!irq_dy_n || !en_q[1]));
  // R5
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !min_tick && !ctrl_wr |=> ($stable(irq_wk_n) && $stable(irq_dy_n)));
endmodule

bind alarm_pair_top alarm_pair_chk u_chk (
  .clk(clk), .rst_n(rst_n), .min_tick(min_tick), .ctrl_wr(ctrl_wr),
  .en_q(en_q), .hit(hit), .irq_wk_n(irq_wk_n), .irq_dy_n(irq_dy_n)
);

// File: tb/alarm_pair_top_tb.sv
module alarm_pair_top_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] cur_min = '0, cur_hour = '0, wr_data = '0;
  logic [2:0] cur_wday = '0, wr_addr = '0;
  logic min_tick = 1'b0, wr_en = 1'b0;
  logic wk_n, dy_n;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  alarm_pair_top u_dut (
    .clk(clk), .rst_n(rst_n), .cur_min(cur_min), .cur_hour(cur_hour),
    .cur_wday(cur_wday), .min_tick(min_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .irq_wk_n(wk_n), .irq_dy_n(dy_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one clock: inputs set at negedge, held across one posedge
  task automatic step(input bit tk, input logic [7:0] m, input logic [7:0] h,
                      input logic [2:0] d, input bit w, input logic [2:0] a,
                      input logic [7:0] v);
    @(negedge clk);
    min_tick = tk; cur_min = m; cur_hour = h; cur_wday = d;
    wr_en = w; wr_addr = a; wr_data = v;
    @(negedge clk);
    min_tick = 1'b0; wr_en = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] v);
    step(1'b0, cur_min, cur_hour, cur_wday, 1'b1, a, v);
  endtask

  task automatic tick(input logic [7:0] m, input logic [7:0] h, input logic [2:0] d);
    step(1'b1, m, h, d, 1'b0, 3'd0, 8'h00);
  endtask

  task automatic t_reset;
    chk(wk_n == 1'b1, "R1 weekly released", wk_n, 1);
    chk(dy_n == 1'b1, "R1 daily released", dy_n, 1);
    tick(8'h00, 8'h00, 3'd0);
    chk(wk_n && dy_n, "R4 disabled after reset", {wk_n, dy_n}, 3);
  endtask

  task automatic t_setup;
    wr(3'd0, 8'h30); wr(3'd1, 8'h10); wr(3'd2, 8'h04);
    wr(3'd3, 8'h15); wr(3'd4, 8'h08); wr(3'd5, 8'h03);
  endtask

  task automatic t_weekly_sticky;
    tick(8'h30, 8'h10, 3'd2);
    chk(wk_n == 1'b0, "R2 weekly match", wk_n, 0);
    chk(dy_n == 1'b1, "R11 daily untouched", dy_n, 1);
    repeat (3) @(negedge clk);
    chk(wk_n == 1'b0, "R5 flag held", wk_n, 0);
    wr(3'd5, 8'h13);
    chk(wk_n == 1'b0, "R5 write 1 keeps flag", wk_n, 0);
    wr(3'd5, 8'h03);
    chk(wk_n == 1'b1, "R5 write 0 clears flag", wk_n, 1);
  endtask

  task automatic t_mask;
    tick(8'h30, 8'h10, 3'd3);
    chk(wk_n == 1'b1, "R2 mask bit clear no match", wk_n, 1);
    wr(3'd2, 8'h7F);
    tick(8'h30, 8'h10, 3'd7);
    chk(wk_n == 1'b1, "R10 weekday 7 no match", wk_n, 1);
    tick(8'h30, 8'h10, 3'd6);
    chk(wk_n == 1'b0, "R2 mask bit 6 match", wk_n, 0);
    wr(3'd5, 8'h03);
  endtask

  task automatic t_notick;
    step(1'b0, 8'h15, 8'h08, 3'd1, 1'b0, 3'd0, 8'h00);
    repeat (2) @(negedge clk);
    chk(dy_n == 1'b1, "R4 no tick no match", dy_n, 1);
  endtask

  task automatic t_daily;
    tick(8'h15, 8'h08, 3'd5);
    chk(dy_n == 1'b0, "R3 daily match any day", dy_n, 0);
    chk(wk_n == 1'b1, "R11 weekly untouched", wk_n, 1);
    wr(3'd5, 8'h03);
    chk(dy_n == 1'b1, "R5 daily cleared", dy_n, 1);
  endtask

  task automatic t_disable;
    tick(8'h15, 8'h08, 3'd0);
    wr(3'd5, 8'h21);
    chk(dy_n == 1'b1, "R6 disable releases", dy_n, 1);
    tick(8'h15, 8'h08, 3'd0);
    chk(dy_n == 1'b1, "R4 disabled no match", dy_n, 1);
    step(1'b1, 8'h15, 8'h08, 3'd0, 1'b1, 3'd5, 8'h03);
    chk(dy_n == 1'b1, "R4 enable with tick no flag", dy_n, 1);
    step(1'b1, 8'h15, 8'h08, 3'd0, 1'b1, 3'd5, 8'h21);
    chk(dy_n == 1'b1, "R6 disable beats tick", dy_n, 1);
    wr(3'd5, 8'h03);
  endtask

  task automatic t_write_collide;
    step(1'b1, 8'h15, 8'h08, 3'd0, 1'b1, 3'd3, 8'h45);
    chk(dy_n == 1'b0, "R7 old minute matched", dy_n, 0);
    wr(3'd5, 8'h03);
    step(1'b1, 8'h15, 8'h08, 3'd0, 1'b1, 3'd3, 8'h15);
    chk(dy_n == 1'b1, "R7 new minute not used", dy_n, 1);
    tick(8'h15, 8'h08, 3'd0);
    chk(dy_n == 1'b0, "R7 new minute next tick", dy_n, 0);
    wr(3'd5, 8'h03);
  endtask

  task automatic t_clear_collide;
    tick(8'h30, 8'h10, 3'd2);
    step(1'b1, 8'h30, 8'h10, 3'd2, 1'b1, 3'd5, 8'h03);
    chk(wk_n == 1'b0, "R8 match beats clear", wk_n, 0);
    wr(3'd5, 8'h03);
    chk(wk_n == 1'b1, "R8 later clear works", wk_n, 1);
  endtask

  task automatic t_pm;
    wr(3'd4, 8'h28);
    tick(8'h15, 8'h08, 3'd0);
    chk(dy_n == 1'b1, "R9 AM hour differs from PM", dy_n, 1);
    tick(8'h15, 8'h28, 3'd0);
    chk(dy_n == 1'b0, "R9 PM hour matches", dy_n, 0);
    wr(3'd5, 8'h03);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_setup;
    t_weekly_sticky;
    t_mask;
    t_notick;
    t_daily;
    t_disable;
    t_write_collide;
    t_clear_collide;
    t_pm;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule